// File: doc/BRIEF.md
# Display Bus Data Lane Reorderer

This block sits between a byte-wide pixel stream and the parallel pins of a display bus. It turns incoming bytes into bus words of either 8 or 16 significant bits and can reorder the data on the way. Three ordering controls are available: a bit mirror, an exchange of the two bytes of a halfword, and an exchange of the two bytes in each consecutive pair, which applies only on the narrow bus. A width select chooses the bus width.

Both sides use a valid/ready handshake. The output word is always 16 bits wide, and its upper byte is zero on the narrow bus. The configuration inputs are static: they change only while the block is empty. A flush input pushes out a lone byte that is still waiting for its partner, so the end of a stream is not lost. The timing of the physical bus strobes and the sequencing of command and data phases belong to other blocks.

Top module: `dlr_lane_reorder`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, and `in_ready` is 1 while `flush` is low.
- R2: With `cfg_wide`=0, `cfg_pairswap`=0 and `cfg_bitrev`=0, each accepted byte b produces one output word equal to {8'h00, b}. On the narrow bus, `out_data[15:8]` is always 0.
- R3: With `cfg_bitrev`=1, bit i of the significant field moves to bit N-1-i. N is 8 on the narrow bus (field [7:0]) and 16 on the wide bus (field [15:0]).
- R4: With `cfg_wide`=1, each two accepted bytes form one word. The first byte goes to bits [7:0] and the second to bits [15:8], before any transform.
- R5: With `cfg_byteswap`=1 on the wide bus, the two bytes of the word are exchanged. On the narrow bus `cfg_byteswap` has no effect on the output.
- R6: When both `cfg_byteswap` and `cfg_bitrev` are set, the byte exchange is applied first and the mirror second. Each transform passes data through unchanged when its control is 0.
- R7: With `cfg_pairswap`=1 on the narrow bus, the first byte of a pair is held and produces no output. When the second byte arrives, the second byte is output, followed by the held byte, and both pass through the bit mirror if it is enabled.
- R8: While `flush` is 1, `in_ready` is 0. If a byte is held, it is emitted alone: as one word on the narrow bus, or with zero in the upper byte before the transforms on the wide bus. With nothing held, flush produces no output.
- R9: Once `out_valid` is 1, it stays 1 and `out_data` stays unchanged until a cycle with `out_ready`=1.
- R10: On the wide bus, `cfg_pairswap` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| cfg_bitrev | input | 1 | Mirror the significant bits of each word |
| cfg_byteswap | input | 1 | Exchange the bytes of a halfword (wide bus only) |
| cfg_pairswap | input | 1 | Emit each consecutive byte pair reversed (narrow bus only) |
| flush | input | 1 | Push out a held odd byte; blocks input while high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | LANE_W | Input byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Receiver takes the word this cycle |
| out_data | output | 2*LANE_W | Output bus word |

## Verification
A hold register that loses or keeps the wrong byte shows up within one word. Either a halfword appears with the wrong lane, or a pair comes out in the wrong order, or a byte is left over at flush or missing. A fault in the second-word slot appears as a dropped or duplicated word on the very next handshake after a pair completes. The bench runs every combination of the four controls with odd-length streams and random back-pressure, so a wrong mux select or a stale output word differs from the queued reference at the first word it affects.

// File: rtl/dlr_pkg.sv
// Shared types for the display lane reorderer.
package dlr_pkg;

    // Static ordering controls, bundled for the transform units.
    typedef struct packed {
        logic wide;      // 1: 16-bit bus
        logic bitrev;    // mirror significant bits
        logic byteswap;  // exchange halfword bytes (wide only)
        logic pairswap;  // reverse byte pairs (narrow only)
    } dlr_cfg_t;

endpackage

// File: rtl/dlr_lane_xform.sv
// Lane transform: packs two lanes into a bus word. It exchanges the lanes
// (wide bus only) and then mirrors the significant bits. On the narrow bus
// only the low lane is significant and the upper lane is forced to zero.
// Assumes: purely combinational; the caller supplies hi as zero when unused.
module dlr_lane_xform
    import dlr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  dlr_cfg_t              cfg,
    input  logic [LANE_W-1:0]     lo,
    input  logic [LANE_W-1:0]     hi,
    output logic [2*LANE_W-1:0]   word
);
    localparam int WORD_W = 2 * LANE_W;

    logic [WORD_W-1:0] packed_w;
    logic [WORD_W-1:0] swapped_w;
    logic [WORD_W-1:0] mirror_wide;
    logic [LANE_W-1:0] mirror_narrow;

    assign packed_w  = {hi, lo};
    // Byte exchange takes effect only on the wide bus, and comes before the mirror.
    assign swapped_w = (cfg.wide && cfg.byteswap) ? {lo, hi} : packed_w;

    // Mirror over the full word.
    for (genvar i = 0; i < WORD_W; i++) begin : g_mir_wide
        assign mirror_wide[i] = swapped_w[WORD_W-1-i];
    end
    // Mirror over the low lane only.
    for (genvar i = 0; i < LANE_W; i++) begin : g_mir_narrow
        assign mirror_narrow[i] = swapped_w[LANE_W-1-i];
    end

    // Select the output form from bus width and mirror control.
    always_comb begin
        if (cfg.wide) begin
            word = cfg.bitrev ? mirror_wide : swapped_w;
        end else begin
            word = {{LANE_W{1'b0}}, (cfg.bitrev ? mirror_narrow : swapped_w[LANE_W-1:0])};
        end
    end
endmodule

// File: rtl/dlr_pair_hold.sv
// One-lane hold buffer: keeps the first byte of a pair until its partner
// arrives or a flush drains it.
// Assumes: capture and release are never both high.
module dlr_pair_hold #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              release_i,
    input  logic [LANE_W-1:0] byte_in,
    output logic              held_vld,
    output logic [LANE_W-1:0] held_byte
);
    // Track whether a byte is waiting and store it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vld  <= 1'b0;
            held_byte <= '0;
        end else if (capture) begin
            held_vld  <= 1'b1;
            held_byte <= byte_in;
        end else if (release_i) begin
            held_vld  <= 1'b0;
        end
    end

    // R7: a held byte is neither lost nor altered until it is released.
    p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_vld && !release_i) |=> (held_vld && $stable(held_byte)));
endmodule

// File: rtl/dlr_out_slot.sv
// Output stage: a registered output word plus one pending word, so that a
// completed swapped pair can present two words back to back. Loads happen
// only when slot_free is high.
// Assumes: load2 is only asserted together with load.
module dlr_out_slot #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              load2,
    input  logic [WORD_W-1:0] load2_word,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              slot_free
);
    logic              pend_vld;
    logic [WORD_W-1:0] pend_word;

    // New data may enter when nothing is pending and the output is empty or leaving.
    assign slot_free = !pend_vld && (!out_valid || out_ready);

    // Advance the pending word on a handshake, then take new loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            pend_vld  <= 1'b0;
            pend_word <= '0;
        end else begin
            if (out_valid && out_ready) begin
                if (pend_vld) begin
                    out_data <= pend_word;
                    pend_vld <= 1'b0;
                end else begin
                    out_valid <= 1'b0;
                end
            end
            if (load) begin
                out_valid <= 1'b1;
                out_data  <= load_word;
            end
            if (load2) begin
                pend_vld  <= 1'b1;
                pend_word <= load2_word;
            end
        end
    end

    // R9: a stalled word is held steady.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7: the second word of a pair follows directly after the first.
    p_second_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && pend_vld) |=> out_valid);
endmodule

// File: rtl/dlr_lane_reorder.sv
// Display bus data lane reorderer (top). Accepts a byte stream and emits
// bus words under the width select and the three ordering controls.
// Assumes: cfg_* inputs change only while the block is empty.
module dlr_lane_reorder
    import dlr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wide,
    input  logic                cfg_bitrev,
    input  logic                cfg_byteswap,
    input  logic                cfg_pairswap,
    input  logic                flush,
    input  logic                in_valid,
    input  logic [LANE_W-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*LANE_W-1:0] out_data
);
    localparam int WORD_W = 2 * LANE_W;

    dlr_cfg_t          cfg;
    logic              slot_free;
    logic              held_vld;
    logic [LANE_W-1:0] held_byte;
    logic              accept, pairing, take_flush, pair_start, pair_done, single;
    logic [LANE_W-1:0] prim_lo, prim_hi;
    logic [LANE_W-1:0] lane_zero;
    logic [WORD_W-1:0] prim_word, held_word, load_word;
    logic              load, load2;

    assign cfg.wide     = cfg_wide;
    assign cfg.bitrev   = cfg_bitrev;
    assign cfg.byteswap = cfg_byteswap;
    assign cfg.pairswap = cfg_pairswap;
    assign lane_zero    = '0;

    // Handshake and event decode.
    assign pairing    = cfg_wide || cfg_pairswap;
    assign in_ready   = slot_free && !flush;
    assign accept     = in_valid && in_ready;
    assign take_flush = flush && held_vld && slot_free;
    assign pair_start = accept && pairing && !held_vld;
    assign pair_done  = accept && pairing && held_vld;
    assign single     = accept && !pairing;

    // Primary word source: a wide pair, or the incoming byte alone.
    assign prim_lo = (pair_done && cfg_wide) ? held_byte : in_data;
    assign prim_hi = (pair_done && cfg_wide) ? in_data   : lane_zero;

    // Output loads: primary word, and the held byte second for a narrow pair.
    assign load      = single || pair_done || take_flush;
    assign load_word = take_flush ? held_word : prim_word;
    assign load2     = pair_done && !cfg_wide;

    dlr_lane_xform #(.LANE_W(LANE_W)) u_xf_prim (
        .cfg(cfg), .lo(prim_lo), .hi(prim_hi), .word(prim_word)
    );

    dlr_lane_xform #(.LANE_W(LANE_W)) u_xf_held (
        .cfg(cfg), .lo(held_byte), .hi(lane_zero), .word(held_word)
    );

    dlr_pair_hold #(.LANE_W(LANE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(pair_start),
        .release_i(pair_done || take_flush), .byte_in(in_data),
        .held_vld(held_vld), .held_byte(held_byte)
    );

    dlr_out_slot #(.WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
        .load2(load2), .load2_word(held_word), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .slot_free(slot_free)
    );

    // R1: reset empties the output.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
    // R2: upper lane is zero on the narrow bus.
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_wide) |-> (out_data[WORD_W-1:LANE_W] == '0));
    // R7: the first byte of a pair produces no output.
    p_first_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_start && (!out_valid || out_ready)) |=> !out_valid);
    // R8: flush with nothing held emits nothing.
    p_flush_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !held_vld && !out_valid) |=> !out_valid);
endmodule

// File: tb/dlr_lane_reorder_tb.sv
// Bench: behavioural queue model, compared on every output handshake.
module dlr_lane_reorder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 0, cfg_bitrev = 0, cfg_byteswap = 0, cfg_pairswap = 0;
    logic        flush = 0, in_valid = 0, out_ready = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, out_valid;
    logic [15:0] out_data;

    int checks = 0, fails = 0, cycles = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    bit          m_held = 0;
    logic [7:0]  m_byte = 0;
    bit          got_accept = 0;
    bit          prev_stall = 0;
    logic [15:0] prev_data = 0;
    string       cur_tag = "R2";

    always #5 clk = ~clk;

    dlr_lane_reorder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_bitrev(cfg_bitrev),
        .cfg_byteswap(cfg_byteswap), .cfg_pairswap(cfg_pairswap), .flush(flush),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [15:0] xf(input logic [7:0] lo, input logic [7:0] hi);
        logic [15:0] w, r;
        int n;
        w = cfg_wide ? {hi, lo} : {8'h00, lo};
        if (cfg_wide && cfg_byteswap) w = {w[7:0], w[15:8]};
        if (cfg_bitrev) begin
            n = cfg_wide ? 16 : 8;
            r = 16'h0;
            for (int i = 0; i < n; i++) r[i] = w[n-1-i];
            w = r;
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    // Sample just before the rising edge, then advance to the falling edge.
    task automatic monitor();
        if (prev_stall) check("R9", {out_valid, out_data}, {1'b1, prev_data});
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) check("R7 unexpected word", out_data, 16'hxxxx);
            else check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        if (in_valid && in_ready) begin
            got_accept = 1;
            if (cfg_wide || cfg_pairswap) begin
                if (!m_held) begin
                    m_held = 1; m_byte = in_data;
                end else begin
                    if (cfg_wide) push(xf(m_byte, in_data), cur_tag);
                    else begin
                        push(xf(in_data, 8'h00), cur_tag);
                        push(xf(m_byte, 8'h00), cur_tag);
                    end
                    m_held = 0;
                end
            end else push(xf(in_data, 8'h00), cur_tag);
        end
        if (flush && m_held) begin
            push(xf(m_byte, 8'h00), "R8");
            m_held = 0;
        end
    endtask

    task automatic cyc();
        #4;
        monitor();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit stress);
        in_valid = 1; in_data = b; got_accept = 0;
        while (!got_accept) begin
            out_ready = stress ? ($urandom_range(0, 3) != 0) : 1'b1;
            cyc();
        end
        in_valid = 0;
    endtask

    task automatic drain();
        flush = 1; out_ready = 1;
        repeat (8) cyc();
        flush = 0;
        repeat (2) cyc();
        check("R8 queue empty", 16'(exp_q.size()), 16'd0);
        check("R8 output idle", {15'd0, out_valid}, 16'd0);
    endtask

    function automatic string pick_tag();
        if (cfg_wide) begin
            if (cfg_byteswap && cfg_bitrev) return "R6";
            if (cfg_byteswap) return "R5";
            if (cfg_bitrev) return "R3";
            if (cfg_pairswap) return "R10";
            return "R4";
        end
        if (cfg_pairswap) return "R7";
        if (cfg_byteswap) return "R5";
        if (cfg_bitrev) return "R3";
        return "R2";
    endfunction

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #4;
        check("R1 out_valid", {15'd0, out_valid}, 16'd0);
        check("R1 in_ready", {15'd0, in_ready}, 16'd1);
        @(negedge clk);

        // R8: flush with nothing held must stay silent.
        flush = 1; out_ready = 1;
        repeat (3) cyc();
        check("R8 idle flush", {15'd0, out_valid}, 16'd0);
        flush = 0;
        cyc();

        for (int c = 0; c < 16; c++) begin
            cfg_wide = c[3]; cfg_bitrev = c[2]; cfg_byteswap = c[1]; cfg_pairswap = c[0];
            cur_tag = pick_tag();
            for (int k = 0; k < 9; k++) begin
                send(8'($urandom_range(0, 255)), k > 1);
                if (k == 0 && cfg_pairswap && !cfg_wide) begin
                    out_ready = 1;
                    repeat (3) cyc();
                    check("R7 first byte held", {15'd0, out_valid}, 16'd0);
                end
            end
            drain();
        end

        // Fixed patterns on the corner values.
        cfg_wide = 1; cfg_bitrev = 1; cfg_byteswap = 1; cfg_pairswap = 0; cur_tag = "R6";
        send(8'h01, 0); send(8'h80, 0);
        drain();
        cfg_wide = 0; cfg_bitrev = 1; cfg_byteswap = 0; cfg_pairswap = 1; cur_tag = "R7";
        send(8'h0F, 0); send(8'hC3, 0); send(8'h5A, 0);
        drain();

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule